// File: doc/BRIEF.md
# Multiple Error Header Log Queue

This block holds the uncorrectable error state of an advanced error reporting capability. It keeps the uncorrectable status register, a pointer to the bit of the error currently logged, and the header and prefix log registers. A record request carries one status bit, four header dwords, four prefix dwords and two valid flags. The first error fills the logs. Later errors, while that first error is still pending and multiple header recording is on, wait in a small in-order queue. When software clears the logged error's status bit, the oldest waiting error is loaded into the logs in the same cycle.

Software reaches the block through two write strobes. One clears status bits (write one to clear). The other sets the multiple header recording enable. A dropped error, lost because the queue was full, gives a one-cycle overflow pulse so that the surrounding logic can raise a header-log-overflow correctable error. Every output is a register that updates on the clock edge after the stimulus. When a write and a record arrive in the same cycle, the write is applied first and the record is applied to the result.

Top module: `err_hdr_log_queue`

## Requirements
- R1: When the synchronous reset is held, the status register, pointer, both logs, the prefix-present flag, the enable, the overflow pulse and the queue all clear to zero or empty.
- R2: A record request whose status, after masking with the supported-bit mask `SUP_MASK` (default 0x03FFF030), has zero bits or more than one bit set is rejected and changes no state.
- R3: An accepted record is logged directly when recording is disabled, or when the status bit at the current pointer is clear. The pointer then takes the index of the single set bit, where bit n of the status word means index n.
- R4: Each log dword i occupies bits [32i+31:32i] and holds the supplied dword with its bytes reversed: supplied bits [31:24] go to log bits [7:0]. The header log is loaded only when the header-valid flag is set, and it reads zero otherwise.
- R5: The prefix log, byte-reversed as in R4, is loaded and the prefix-present flag is set only when both the prefix-valid flag and the `pfx_cap` input are 1. Otherwise the prefix log is zero and the flag is 0.
- R6: An accepted record that arrives while recording is enabled and the pointed-to status bit is set is queued. The logs and the pointer are left unchanged.
- R7: A record that should be queued into a full queue is dropped, and `log_overflow` is 1 for exactly one cycle. In both R6 and R7 the record's status bit is still set.
- R8: A status write clears exactly the written 1 bits that lie within `SUP_MASK`. Status bits outside the mask always read 0.
- R9: After a status or control write, if the pointed-to bit is clear and either recording is disabled or the queue is empty, the pointer, the prefix-present flag and both logs clear to zero.
- R10: After such a write with the pointed-to bit clear, recording enabled and a non-empty queue, the status bits of all queued entries are set again and the oldest entry is removed and logged. Entries leave in arrival order.
- R11: After a write that leaves the pointed-to bit set with recording enabled, the status bits of all queued entries are forced back to 1.
- R12: After a write that leaves the pointed-to bit set with recording disabled, the queue is emptied.
- R13: A write and a record in the same cycle act as the write followed by the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid | input | 1 | Record request strobe |
| rec_status | input | 32 | One-hot error status bit of the request |
| rec_hdr_vld | input | 1 | Header dwords are valid |
| rec_hdr | input | 128 | Four header dwords, dword i at [32i+31:32i] |
| rec_pfx_vld | input | 1 | Prefix dwords are present |
| rec_pfx | input | 128 | Four prefix dwords, dword i at [32i+31:32i] |
| pfx_cap | input | 1 | End-to-end prefix support is advertised |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 32 | Write-one-to-clear data for the status register |
| ctl_wr | input | 1 | Control write strobe |
| ctl_mhr | input | 1 | Multiple header recording enable value to write |
| uncor_status | output | 32 | Uncorrectable error status register |
| first_ptr | output | 5 | Bit index of the logged error |
| hdr_log | output | 128 | Header log, byte-reversed dwords |
| pfx_log | output | 128 | Prefix log, byte-reversed dwords |
| pfx_present | output | 1 | Prefix log holds a valid prefix |
| mhr_en | output | 1 | Multiple header recording enable |
| log_overflow | output | 1 | One-cycle pulse: a queued error was dropped |

## Verification
The bench builds the block with a queue depth of 2 and the default supported mask. At that depth a third pending error reaches the full-queue drop and its overflow pulse after only two accepted pushes, and draining the queue through successive clears shows the arrival order in two steps. Emptying the queue with recording disabled is made visible by re-enabling recording and clearing the pointed-to bit: the logs then clear instead of loading a stale entry. A write and a record in the same cycle, and a prefix offered with support withdrawn, are driven as directed cases after the vector table.

// File: rtl/ehlq_pkg.sv
package ehlq_pkg;

    localparam int ERR_W  = 32;
    localparam int DW_W   = 32;
    localparam int LOG_DW = 4;
    localparam int LOG_W  = DW_W * LOG_DW;
    localparam int IDX_W  = $clog2(ERR_W);

    typedef struct packed {
        logic [ERR_W-1:0] status;
        logic             hdr_vld;
        logic [LOG_W-1:0] hdr;
        logic             pfx_vld;
        logic [LOG_W-1:0] pfx;
    } err_rec_t;

    function automatic logic [IDX_W-1:0] lowest_bit(input logic [ERR_W-1:0] v);
        logic [IDX_W-1:0] idx;
        idx = '0;
        for (int i = ERR_W - 1; i >= 0; i--) begin
            if (v[i]) idx = IDX_W'(i);
        end
        return idx;
    endfunction

    function automatic logic is_single(input logic [ERR_W-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction

    function automatic logic [LOG_W-1:0] dword_swap(input logic [LOG_W-1:0] v);
        logic [LOG_W-1:0] r;
        for (int d = 0; d < LOG_DW; d++) begin
            for (int b = 0; b < DW_W / 8; b++) begin
                r[d*DW_W + 8*b +: 8] = v[d*DW_W + 8*(DW_W/8 - 1 - b) +: 8];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ehlq_queue.sv
module ehlq_queue
    import ehlq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     pop,
    input  logic                     push,
    input  err_rec_t                 push_rec,
    output err_rec_t                 head_rec,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic [ERR_W-1:0]         pend_status
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    err_rec_t           mem [DEPTH];
    logic [DEPTH-1:0]   vld_q, vld_n;
    logic [PTR_W-1:0]   rd_q, rd_n, wr_q, wr_n, wr_idx;
    logic [CNT_W-1:0]   lvl_q, lvl_n;
    logic [ERR_W-1:0]   slot_st [DEPTH];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        rd_n  = flush ? '0 : rd_q;
        wr_n  = flush ? '0 : wr_q;
        lvl_n = flush ? '0 : lvl_q;
        vld_n = flush ? '0 : vld_q;
        if (pop) begin
            vld_n[rd_n] = 1'b0;
            rd_n        = ptr_inc(rd_n);
            lvl_n       = lvl_n - 1'b1;
        end
        wr_idx = wr_n;
        if (push) begin
            vld_n[wr_n] = 1'b1;
            wr_n        = ptr_inc(wr_n);
            lvl_n       = lvl_n + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            lvl_q <= '0;
            vld_q <= '0;
        end else begin
            rd_q  <= rd_n;
            wr_q  <= wr_n;
            lvl_q <= lvl_n;
            vld_q <= vld_n;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_idx] <= push_rec;
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        assign slot_st[k] = vld_q[k] ? mem[k].status : '0;
    end

    always_comb begin
        pend_status = '0;
        for (int k = 0; k < DEPTH; k++) pend_status = pend_status | slot_st[k];
    end

    assign head_rec = mem[rd_q];
    assign level    = lvl_q;

    // R7
    q_room_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush) |-> (lvl_q < CNT_W'(DEPTH)));

    // R10
    q_pop_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> (lvl_q != '0));

endmodule

// File: rtl/ehlq_log.sv
module ehlq_log
    import ehlq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  err_rec_t         load_rec,
    input  logic             clear,
    input  logic             pfx_cap,
    output logic [IDX_W-1:0] fep,
    output logic [LOG_W-1:0] hdr_log,
    output logic [LOG_W-1:0] pfx_log,
    output logic             pfx_present
);

    logic take_pfx;
    assign take_pfx = load_rec.pfx_vld && pfx_cap;

    always_ff @(posedge clk) begin
        if (rst || (clear && !load)) begin
            fep         <= '0;
            hdr_log     <= '0;
            pfx_log     <= '0;
            pfx_present <= 1'b0;
        end else if (load) begin
            fep         <= lowest_bit(load_rec.status);
            hdr_log     <= load_rec.hdr_vld ? dword_swap(load_rec.hdr) : '0;
            pfx_log     <= take_pfx ? dword_swap(load_rec.pfx) : '0;
            pfx_present <= take_pfx;
        end
    end

    // R9
    log_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clear && !load) |=> (fep == '0 && hdr_log == '0 && pfx_log == '0 && !pfx_present));

    // R5
    pfx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !(load_rec.pfx_vld && pfx_cap)) |=> (!pfx_present && pfx_log == '0));

    // R4
    hdr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !load_rec.hdr_vld) |=> (hdr_log == '0));

endmodule

// File: rtl/err_hdr_log_queue.sv
module err_hdr_log_queue
    import ehlq_pkg::*;
#(
    parameter int               QDEPTH   = 4,
    parameter logic [ERR_W-1:0] SUP_MASK = 32'h03FF_F030
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rec_valid,
    input  logic [31:0]      rec_status,
    input  logic             rec_hdr_vld,
    input  logic [127:0]     rec_hdr,
    input  logic             rec_pfx_vld,
    input  logic [127:0]     rec_pfx,
    input  logic             pfx_cap,
    input  logic             sts_wr,
    input  logic [31:0]      sts_wdata,
    input  logic             ctl_wr,
    input  logic             ctl_mhr,
    output logic [31:0]      uncor_status,
    output logic [4:0]       first_ptr,
    output logic [127:0]     hdr_log,
    output logic [127:0]     pfx_log,
    output logic             pfx_present,
    output logic             mhr_en,
    output logic             log_overflow
);

    localparam int CNT_W = $clog2(QDEPTH + 1);

    logic [ERR_W-1:0] status_q, st_w, st_e, st_n, rec_bit, q_pend;
    logic             mhr_q, mhr_n, ovf_q, ovf_w;
    logic [IDX_W-1:0] ptr_q, ptr_w;
    logic             q_pop, q_push, q_flush, log_clear, log_load, direct, rec_ok;
    logic [CNT_W-1:0] q_level;
    int               lvl_eff;
    err_rec_t         rec_in, q_head, log_rec;

    assign rec_in = '{status:  rec_status & SUP_MASK,
                      hdr_vld: rec_hdr_vld,
                      hdr:     rec_hdr,
                      pfx_vld: rec_pfx_vld,
                      pfx:     rec_pfx};

    always_comb begin
        // software write stage
        mhr_n     = ctl_wr ? ctl_mhr : mhr_q;
        st_w      = sts_wr ? (status_q & ~(sts_wdata & SUP_MASK)) : status_q;
        st_e      = st_w;
        ptr_w     = ptr_q;
        q_pop     = 1'b0;
        q_flush   = 1'b0;
        log_clear = 1'b0;
        if (sts_wr || ctl_wr) begin
            if (!st_w[ptr_q]) begin
                if (!mhr_n || q_level == '0) begin
                    log_clear = 1'b1;
                    ptr_w     = '0;
                end else begin
                    st_e  = st_w | q_pend;
                    q_pop = 1'b1;
                    ptr_w = lowest_bit(q_head.status);
                end
            end else if (mhr_n) begin
                st_e = st_w | q_pend;
            end else begin
                q_flush = 1'b1;
            end
        end

        // record stage, applied after the write
        rec_bit = rec_in.status;
        rec_ok  = rec_valid && is_single(rec_bit);
        lvl_eff = q_flush ? 0 : (int'(q_level) - int'(q_pop));
        q_push  = 1'b0;
        ovf_w   = 1'b0;
        direct  = 1'b0;
        st_n    = st_e;
        if (rec_ok) begin
            if (mhr_n && st_e[ptr_w]) begin
                if (lvl_eff < QDEPTH) q_push = 1'b1;
                else                  ovf_w  = 1'b1;
            end else begin
                direct = 1'b1;
            end
            st_n = st_e | rec_bit;
        end

        log_load = q_pop || direct;
        log_rec  = direct ? rec_in : q_head;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mhr_q    <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            status_q <= st_n;
            mhr_q    <= mhr_n;
            ovf_q    <= ovf_w;
        end
    end

    ehlq_queue #(.DEPTH(QDEPTH)) u_queue (
        .clk         (clk),
        .rst         (rst),
        .flush       (q_flush),
        .pop         (q_pop),
        .push        (q_push),
        .push_rec    (rec_in),
        .head_rec    (q_head),
        .level       (q_level),
        .pend_status (q_pend)
    );

    ehlq_log u_log (
        .clk         (clk),
        .rst         (rst),
        .load        (log_load),
        .load_rec    (log_rec),
        .clear       (log_clear),
        .pfx_cap     (pfx_cap),
        .fep         (ptr_q),
        .hdr_log     (hdr_log),
        .pfx_log     (pfx_log),
        .pfx_present (pfx_present)
    );

    assign uncor_status = status_q;
    assign first_ptr    = ptr_q;
    assign mhr_en       = mhr_q;
    assign log_overflow = ovf_q;

    // R8
    unsup_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (status_q & ~SUP_MASK) == '0);

    // R2
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !is_single(rec_status & SUP_MASK) && !sts_wr && !ctl_wr)
        |=> $stable(status_q));

    // R7
    ovf_full_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> ($past(q_level) == CNT_W'(QDEPTH)));

    // R10
    pop_sets_chk: assert property (@(posedge clk) disable iff (rst)
        q_pop |=> status_q[ptr_q]);

    // R12
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (q_flush && !q_push) |=> (q_level == '0));

endmodule

// File: tb/tb_err_hdr_log_queue.sv
`timescale 1ns/1ps
module tb_err_hdr_log_queue;

    logic         clk = 1'b0;
    logic         rst;
    logic         rec_valid, rec_hdr_vld, rec_pfx_vld, pfx_cap;
    logic [31:0]  rec_status, sts_wdata;
    logic [127:0] rec_hdr, rec_pfx;
    logic         sts_wr, ctl_wr, ctl_mhr;
    logic [31:0]  uncor_status;
    logic [4:0]   first_ptr;
    logic [127:0] hdr_log, pfx_log;
    logic         pfx_present, mhr_en, log_overflow;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    err_hdr_log_queue #(.QDEPTH(2)) dut (
        .clk(clk), .rst(rst),
        .rec_valid(rec_valid), .rec_status(rec_status),
        .rec_hdr_vld(rec_hdr_vld), .rec_hdr(rec_hdr),
        .rec_pfx_vld(rec_pfx_vld), .rec_pfx(rec_pfx),
        .pfx_cap(pfx_cap), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
        .ctl_wr(ctl_wr), .ctl_mhr(ctl_mhr),
        .uncor_status(uncor_status), .first_ptr(first_ptr),
        .hdr_log(hdr_log), .pfx_log(pfx_log), .pfx_present(pfx_present),
        .mhr_en(mhr_en), .log_overflow(log_overflow)
    );

    typedef struct packed {
        logic [1:0]  op;    // 0 record, 1 status write, 2 control write
        logic [31:0] data;
        logic        hv;
        logic [31:0] est;
        logic [4:0]  efep;
        logic        ehv;
        logic        eovf;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{2'd2, 32'h0000_0001, 1'b0, 32'h0000_0000, 5'd0,  1'b0, 1'b0},
        '{2'd0, 32'h0000_1000, 1'b1, 32'h0000_1000, 5'd12, 1'b1, 1'b0},
        '{2'd0, 32'h0000_2000, 1'b1, 32'h0000_3000, 5'd12, 1'b1, 1'b0},
        '{2'd0, 32'h0000_4000, 1'b1, 32'h0000_7000, 5'd12, 1'b1, 1'b0},
        '{2'd0, 32'h0000_8000, 1'b1, 32'h0000_F000, 5'd12, 1'b1, 1'b1},
        '{2'd1, 32'h0000_2000, 1'b0, 32'h0000_F000, 5'd12, 1'b1, 1'b0},
        '{2'd1, 32'h0000_1000, 1'b0, 32'h0000_E000, 5'd13, 1'b1, 1'b0},
        '{2'd1, 32'h0000_2000, 1'b0, 32'h0000_C000, 5'd14, 1'b1, 1'b0},
        '{2'd1, 32'h0000_4000, 1'b0, 32'h0000_8000, 5'd0,  1'b0, 1'b0},
        '{2'd0, 32'h0000_3000, 1'b1, 32'h0000_8000, 5'd0,  1'b0, 1'b0},
        '{2'd0, 32'h0000_0001, 1'b1, 32'h0000_8000, 5'd0,  1'b0, 1'b0},
        '{2'd0, 32'h0000_0010, 1'b0, 32'h0000_8010, 5'd4,  1'b0, 1'b0},
        '{2'd0, 32'h0010_0000, 1'b1, 32'h0010_8010, 5'd4,  1'b0, 1'b0},
        '{2'd2, 32'h0000_0000, 1'b0, 32'h0010_8010, 5'd4,  1'b0, 1'b0},
        '{2'd2, 32'h0000_0001, 1'b0, 32'h0010_8010, 5'd4,  1'b0, 1'b0},
        '{2'd1, 32'h0000_0010, 1'b0, 32'h0010_8000, 5'd0,  1'b0, 1'b0},
        '{2'd1, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 5'd0,  1'b0, 1'b0},
        '{2'd2, 32'h0000_0000, 1'b0, 32'h0000_0000, 5'd0,  1'b0, 1'b0},
        '{2'd0, 32'h0000_0020, 1'b1, 32'h0000_0020, 5'd5,  1'b1, 1'b0},
        '{2'd0, 32'h0020_0000, 1'b1, 32'h0020_0020, 5'd21, 1'b1, 1'b0}
    };
    localparam string TAG [NV] = '{
        "R9", "R3", "R6", "R6", "R7", "R11", "R10", "R10", "R9", "R2",
        "R2", "R4", "R6", "R12", "R11", "R12", "R8", "R9", "R3", "R3"
    };

    function automatic logic [127:0] hdr_of(input int idx);
        logic [127:0] r;
        for (int i = 0; i < 4; i++) r[32*i +: 32] = {8'hA0 + 8'(i), 8'(idx), 8'h5A, 8'(i)};
        return r;
    endfunction

    function automatic logic [127:0] pfx_of(input int idx);
        logic [127:0] r;
        for (int i = 0; i < 4; i++) r[32*i +: 32] = {8'hB0 + 8'(i), 8'(idx), 8'hC3, 8'(i + 8)};
        return r;
    endfunction

    function automatic logic [127:0] rev_bytes(input logic [127:0] v);
        logic [127:0] r;
        for (int i = 0; i < 4; i++)
            r[32*i +: 32] = {v[32*i +: 8], v[32*i+8 +: 8], v[32*i+16 +: 8], v[32*i+24 +: 8]};
        return r;
    endfunction

    function automatic int bit_index(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rec_valid = 1'b0; rec_status = '0; rec_hdr_vld = 1'b0; rec_hdr = '0;
        rec_pfx_vld = 1'b0; rec_pfx = '0; sts_wr = 1'b0; sts_wdata = '0;
        ctl_wr = 1'b0; ctl_mhr = 1'b0;
    endtask

    task automatic apply(input logic [1:0] op, input logic [31:0] data,
                         input logic hv, input logic pv);
        @(negedge clk);
        idle_inputs();
        case (op)
            2'd0: begin
                rec_valid = 1'b1; rec_status = data; rec_hdr_vld = hv;
                rec_hdr = hdr_of(bit_index(data)); rec_pfx_vld = pv;
                rec_pfx = pfx_of(bit_index(data));
            end
            2'd1: begin sts_wr = 1'b1; sts_wdata = data; end
            default: begin ctl_wr = 1'b1; ctl_mhr = data[0]; end
        endcase
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic check_reset_state(input string tag);
        check(tag, "status", 128'(uncor_status), 128'h0);
        check(tag, "pointer", 128'(first_ptr), 128'h0);
        check(tag, "hdr_log", hdr_log, 128'h0);
        check(tag, "pfx_log", pfx_log, 128'h0);
        check(tag, "pfx_present", 128'(pfx_present), 128'h0);
        check(tag, "mhr_en", 128'(mhr_en), 128'h0);
        check(tag, "overflow", 128'(log_overflow), 128'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle_inputs();
        pfx_cap = 1'b1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_reset_state("R1");

        for (int v = 0; v < NV; v++) begin
            apply(TBL[v].op, TBL[v].data, TBL[v].hv, 1'b0);
            check(TAG[v], $sformatf("row %0d status", v), 128'(uncor_status), 128'(TBL[v].est));
            check(TAG[v], $sformatf("row %0d pointer", v), 128'(first_ptr), 128'(TBL[v].efep));
            check(TAG[v], $sformatf("row %0d hdr_log", v), hdr_log,
                  TBL[v].ehv ? rev_bytes(hdr_of(int'(TBL[v].efep))) : 128'h0);
            check(TAG[v], $sformatf("row %0d overflow", v), 128'(log_overflow), 128'(TBL[v].eovf));
            check(TAG[v], $sformatf("row %0d pfx_present", v), 128'(pfx_present), 128'h0);
        end

        // R5 prefix with support advertised
        apply(2'd0, 32'h0040_0000, 1'b1, 1'b1);
        check("R5", "prefix loaded", pfx_log, rev_bytes(pfx_of(22)));
        check("R5", "prefix present", 128'(pfx_present), 128'h1);
        check("R4", "header swap bit22", hdr_log, rev_bytes(hdr_of(22)));

        // R5 prefix offered without support
        pfx_cap = 1'b0;
        apply(2'd0, 32'h0080_0000, 1'b1, 1'b1);
        check("R5", "prefix zero no cap", pfx_log, 128'h0);
        check("R5", "prefix flag no cap", 128'(pfx_present), 128'h0);
        check("R3", "pointer bit23", 128'(first_ptr), 128'd23);
        pfx_cap = 1'b1;

        // R13 write and record in one cycle: clear bit 23 then log bit 24
        @(negedge clk);
        idle_inputs();
        sts_wr = 1'b1; sts_wdata = 32'h0080_0000;
        rec_valid = 1'b1; rec_status = 32'h0100_0000; rec_hdr_vld = 1'b1;
        rec_hdr = hdr_of(24);
        @(negedge clk);
        idle_inputs();
        check("R13", "status", 128'(uncor_status), 128'h0160_0020);
        check("R13", "pointer", 128'(first_ptr), 128'd24);
        check("R13", "hdr_log", hdr_log, rev_bytes(hdr_of(24)));

        // R8 unsupported-only write leaves status
        apply(2'd1, 32'hFC00_0FCF, 1'b0, 1'b0);
        check("R8", "unsupported write", 128'(uncor_status), 128'h0160_0020);

        // R1 reset mid-run
        apply(2'd2, 32'h1, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_reset_state("R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule